// File: doc/BRIEF.md
# Field Prescaler with Select Detector

This block takes a 22-bit two's-complement data word and shifts it right, keeping its sign, by a programmable amount. The result is an 8-bit window of the word, placed at the least significant end, which a downstream lookup stage uses as its address. The shift control is 5 bits wide. The useful range of shifts is 0 to 16, and larger codes act as 16.

The block also checks whether the chosen window can hold the shifted value. When it cannot, it raises one of two flags. The overselect flag means a positive value was too large for the window. The underselect flag means a negative value fell outside it.

A mode input chooses how the address is read:
- In signed mode the address covers -128 to 127.
- In unsigned mode it covers 0 to 255, and every negative input is reported as an underselect.

All outputs are registered and change one clock after the inputs are presented.

Top module: `fsel_prescaler`

## Requirements
- R1: While reset is high at a rising edge, the registered outputs become address 0 with both flags low by the next cycle.
- R2: The address equals bits 7..0 of the 22-bit input shifted right arithmetically (bit 21 is the sign and is replicated) by the effective shift amount.
- R3: Shift control codes 17 to 31 give exactly the same results as code 16.
- R4: In signed mode (mode input 0), a select error exists when any of bits 21..8 of the shifted word differs from its bit 7. That is, the shifted value lies outside -128..127.
- R5: A select error on an input with bit 21 equal to 0 raises the overselect flag only. A select error on an input with bit 21 equal to 1 raises the underselect flag only.
- R6: In unsigned mode (mode input 1), a select error exists when any of bits 21..8 of the shifted word is 1. That is, the shifted value lies outside 0..255. For a non-negative input, such an error raises the overselect flag.
- R7: In unsigned mode, every input with bit 21 set raises the underselect flag, whatever the shift amount.
- R8: The overselect and underselect flags are never high together.
- R9: Each result appears on the outputs exactly one clock after its inputs were sampled. A new input set is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 22 | Two's-complement data word, bit 21 is the sign |
| shift_i | input | 5 | Right-shift amount; codes above 16 act as 16 |
| pos_mode_i | input | 1 | 0 = signed address, 1 = unsigned address |
| addr_o | output | 8 | Registered window address |
| over_o | output | 1 | Registered overselect flag |
| under_o | output | 1 | Registered underselect flag |

## Verification
The address and both flags are due one rising edge after the inputs that produce them. No other result takes a different latency.

The bench drives a new input set at each falling edge and stamps the expected item with the cycle in which it falls due. The monitor compares an item only at the falling edge that follows that rising edge.

Input sets change every cycle back to back. This shows that no result leaks into a neighbouring cycle.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    // Default geometry of the data word and the selected window.
    localparam int XBUS_W    = 22;
    localparam int WIN_W     = 8;
    localparam int SHCTL_W   = 5;
    localparam int SHIFT_MAX = 16;

    // Interpretation of the selected window.
    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } addr_mode_e;

    // Saturation flags carried together through the datapath.
    typedef struct packed {
        logic over;
        logic under;
    } sel_flags_t;

    // Split a select error into its polarity by the input sign.
    function automatic sel_flags_t split_error(input logic err, input logic sign);
        sel_flags_t f;
        f.over  = err & ~sign;
        f.under = err & sign;
        return f;
    endfunction

endpackage

// File: rtl/fsel_shifter.sv
module fsel_shifter #(
    parameter int XW    = fsel_pkg::XBUS_W,
    parameter int CW    = fsel_pkg::SHCTL_W,
    parameter int MAXSH = fsel_pkg::SHIFT_MAX
) (
    input  logic [XW-1:0] x_i,
    input  logic [CW-1:0] shctl_i,
    output logic [XW-1:0] shifted_o
);
    localparam int STAGES = $clog2(MAXSH + 1);

    logic [STAGES-1:0] sh_eff;
    logic [XW-1:0]     stg [STAGES+1];

    // Codes beyond the maximum saturate to the maximum shift.
    always_comb begin
        if (shctl_i > CW'(MAXSH)) sh_eff = STAGES'(MAXSH);
        else                      sh_eff = STAGES'(shctl_i);
    end

    assign stg[0] = x_i;

    // Logarithmic arithmetic shifter: stage k moves by 2**k places.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stg[k+1] = sh_eff[k] ? XW'($signed(stg[k]) >>> (2 ** k)) : stg[k];
    end

    assign shifted_o = stg[STAGES];

endmodule

// File: rtl/fsel_detect.sv
module fsel_detect #(
    parameter int XW = fsel_pkg::XBUS_W,
    parameter int AW = fsel_pkg::WIN_W
) (
    input  logic [XW-1:0]          shifted_i,
    input  fsel_pkg::addr_mode_e   mode_i,
    input  logic                   sign_i,
    output fsel_pkg::sel_flags_t   flags_o
);
    import fsel_pkg::*;

    localparam int UPW = XW - AW;

    logic           ref_bit;
    logic [UPW-1:0] mism;
    logic           err;

    // Signed window: upper bits must copy the window's top bit.
    // Unsigned window: upper bits must all be zero.
    assign ref_bit = (mode_i == MODE_UNSIGNED) ? 1'b0 : shifted_i[AW-1];

    for (genvar i = 0; i < UPW; i++) begin : g_cmp
        assign mism[i] = shifted_i[AW+i] ^ ref_bit;
    end

    assign err     = |mism;
    assign flags_o = split_error(err, sign_i);

endmodule

// File: rtl/fsel_prescaler.sv
module fsel_prescaler #(
    parameter int XW    = fsel_pkg::XBUS_W,
    parameter int AW    = fsel_pkg::WIN_W,
    parameter int CW    = fsel_pkg::SHCTL_W,
    parameter int MAXSH = fsel_pkg::SHIFT_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_i,
    input  logic [CW-1:0] shift_i,
    input  logic          pos_mode_i,
    output logic [AW-1:0] addr_o,
    output logic          over_o,
    output logic          under_o
);
    import fsel_pkg::*;

    logic [XW-1:0] shifted;
    addr_mode_e    mode;
    sel_flags_t    flags;

    assign mode = addr_mode_e'(pos_mode_i);

    fsel_shifter #(.XW(XW), .CW(CW), .MAXSH(MAXSH)) u_shift (
        .x_i       (x_i),
        .shctl_i   (shift_i),
        .shifted_o (shifted)
    );

    fsel_detect #(.XW(XW), .AW(AW)) u_det (
        .shifted_i (shifted),
        .mode_i    (mode),
        .sign_i    (x_i[XW-1]),
        .flags_o   (flags)
    );

    // Single output register stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            over_o  <= 1'b0;
            under_o <= 1'b0;
        end else begin
            addr_o  <= shifted[AW-1:0];
            over_o  <= flags.over;
            under_o <= flags.under;
        end
    end

    // R1: reset clears the registered outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (addr_o == '0 && !over_o && !under_o));

    // R2: a zero word maps to address zero without flags
    a_r2_zero_word: assert property (@(posedge clk) disable iff (rst)
        (x_i == '0) |=> (addr_o == '0 && !over_o && !under_o));

    // R5: a non-negative word never reports underselect
    a_r5_pos_no_under: assert property (@(posedge clk) disable iff (rst)
        !x_i[XW-1] |=> !under_o);

    // R5: a negative word never reports overselect
    a_r5_neg_no_over: assert property (@(posedge clk) disable iff (rst)
        x_i[XW-1] |=> !over_o);

    // R7: unsigned mode with a negative word always underselects
    a_r7_neg_unsigned: assert property (@(posedge clk) disable iff (rst)
        (pos_mode_i && x_i[XW-1]) |=> under_o);

    // R8: flags are mutually exclusive
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(over_o && under_o));

endmodule

// File: tb/sim_fsel_prescaler.sv
`timescale 1ns/1ps
module sim_fsel_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] x_r = '0;
    logic [4:0]  sh_r = '0;
    logic        md_r = 1'b0;
    logic [7:0]  addr;
    logic        ovr;
    logic        und;

    always #2 clk = ~clk;

    fsel_prescaler u0 (
        .clk        (clk),
        .rst        (rst),
        .x_i        (x_r),
        .shift_i    (sh_r),
        .pos_mode_i (md_r),
        .addr_o     (addr),
        .over_o     (ovr),
        .under_o    (und)
    );

    typedef struct {
        logic [7:0] addr;
        logic       over;
        logic       under;
        int         due;
        string      req;
    } exp_t;

    exp_t  sbq[$];
    exp_t  mon_e;
    int    cyc      = 0;
    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model taken from the requirements, in integer arithmetic.
    task automatic drive(input logic [21:0] x, input logic [4:0] s,
                         input logic m, input string req);
        int   xs;
        int   sh;
        int   v;
        bit   err;
        exp_t e;
        @(negedge clk);
        x_r  = x;
        sh_r = s;
        md_r = m;
        xs   = $signed(x);
        sh   = (s > 5'd16) ? 16 : int'(s);
        v    = xs >>> sh;
        err  = m ? (v < 0 || v > 255) : (v < -128 || v > 127);
        e.addr  = v[7:0];
        e.over  = err && (xs >= 0);
        e.under = err && (xs < 0);
        e.due   = cyc + 1;
        e.req   = req;
        sbq.push_back(e);
    endtask

    // Monitor: compare each item at the falling edge after its due rising edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            mon_e = sbq.pop_front();
            checks++;
            if (addr !== mon_e.addr || ovr !== mon_e.over || und !== mon_e.under) begin
                failures++;
                $display("FAIL %s: addr=%h over=%b under=%b expected addr=%h over=%b under=%b",
                         mon_e.req, addr, ovr, und, mon_e.addr, mon_e.over, mon_e.under);
            end
            checks++;
            if (ovr === 1'b1 && und === 1'b1) begin
                failures++;
                $display("FAIL R8: over=%b under=%b expected not both set", ovr, und);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        checks++;
        if (addr !== 8'h00 || ovr !== 1'b0 || und !== 1'b0) begin
            failures++;
            $display("FAIL R1: addr=%h over=%b under=%b expected 00 0 0", addr, ovr, und);
        end
        rst = 1'b0;

        // R4 / R5 signed window edges
        drive(22'h00007F, 5'd0, 1'b0, "R4");
        drive(22'h000080, 5'd0, 1'b0, "R4,R5");
        drive(22'h3FFF80, 5'd0, 1'b0, "R4");
        drive(22'h3FFF7F, 5'd0, 1'b0, "R4,R5");
        drive(22'h0001FF, 5'd1, 1'b0, "R5");
        drive(22'h0000FF, 5'd1, 1'b0, "R4");
        // R6 unsigned window edges
        drive(22'h0000FF, 5'd0, 1'b1, "R6");
        drive(22'h000100, 5'd0, 1'b1, "R6");
        drive(22'h01FFFF, 5'd9, 1'b1, "R6");
        drive(22'h020000, 5'd9, 1'b1, "R6");
        // R7 negative words in unsigned mode
        drive(22'h3FFFFF, 5'd0, 1'b1, "R7");
        drive(22'h200000, 5'd16, 1'b1, "R7");
        drive(22'h200000, 5'd16, 1'b0, "R4");
        // R2 plain shifts
        drive(22'h1FFFFF, 5'd16, 1'b0, "R2");
        drive(22'h0ABCDE, 5'd12, 1'b0, "R2");
        drive(22'h000000, 5'd7, 1'b1, "R2");
        // R3 clamped shift codes
        drive(22'h123456, 5'd17, 1'b0, "R3");
        drive(22'h123456, 5'd31, 1'b1, "R3");
        drive(22'h2ABCDE, 5'd20, 1'b0, "R3");
        drive(22'h2ABCDE, 5'd24, 1'b1, "R3");

        // R9 back-to-back random traffic, one new set per cycle
        for (int i = 0; i < 400; i++) begin
            drive(22'($urandom), 5'($urandom), 1'($urandom), "R2,R9");
        end

        repeat (3) @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            failures++;
            $display("FAIL R9: %0d results outstanding expected 0", sbq.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule